// File: doc/BRIEF.md
# Serial EEPROM Slave Command Engine

This block is the command side of a serial EEPROM slave. A fast system clock oversamples the four host pins (serial clock, active-low select, data in, active-low pause) through synchronizers. The engine derives clock edges from the sampled pins and decodes an 8-bit command sent most significant bit first. It then runs the phase that the command selects: a 16-bit address, a streamed array read, buffered page loading, a status read or a status write. The serial output has its own enable, so the pin can float.

Array storage sits outside the block behind a plain register-file port with a combinational read. A neighbouring status and protection unit supplies the write-enable flag, the busy flag, the status byte and a per-address protection verdict. The engine returns pulses that set or clear write enable, load the status register, and start the timed write cycle. Page data collects in a 64-byte staging buffer. The buffer is copied into the array only when the select pin rises on a clean byte boundary.

Top module: `eeprom_cmd_engine`

## Requirements
- R1: Commands are 8 bits, MSB first, decoded on the eighth rising serial clock: 0x06 set write enable, 0x04 clear write enable, 0x05 status read, 0x01 status write, 0x03 array read, 0x02 array write.
- R2: Input data is taken on rising serial clock edges and output data changes on falling edges, so the block works with the clock idling low (mode 0) and idling high (mode 3).
- R3: Array read and write take a 16-bit address after the command, and the top bit is ignored. A read streams bytes MSB first while clocks continue. The address advances after each byte and wraps from 0x7FFF to 0x0000.
- R4: Array write data bytes go to the staging buffer at the address's low 6 bits. That offset wraps within the 64-byte page, and a later byte at the same offset replaces the earlier one.
- R5: An array write is committed only if the select rises with a whole number of data bytes received (at least one) and write enable set. The commit gives a one-cycle `wr_start_o` pulse. Any other rise discards the write.
- R6: Set and clear write enable produce a one-cycle `wel_set_o` or `wel_clr_o` pulse only when the select rises right after the eighth command bit. Extra clock edges cancel the command.
- R7: The status write takes one data byte. On a rise right after that byte with write enable set, `sr_we_o` and `wr_start_o` pulse together. `sr_wdata_o` carries bits 7, 4, 3 and 2 of the byte, with bits 6, 5, 1 and 0 forced to 0.
- R8: Pulling the pause pin low while the serial clock is low floats the output and makes serial clock edges ignored. Releasing it while the clock is low resumes at the same bit.
- R9: `so_oe` is low whenever the select is high. After reset a falling select edge is needed, so a select held low through reset gets no response.
- R10: Unknown commands are ignored until the select rises. While `busy_i` is high or a commit is running, every command except status read is ignored.
- R11: A commit writes only the buffer offsets that were loaded. It never asserts `mem_we_o` while `prot_i` flags the presented address.
- R12: A status read outputs `sr_i` MSB first and repeats it for every further byte clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Host serial clock (asynchronous) |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for `so` |
| busy_i | input | 1 | Timed write cycle in progress |
| wel_i | input | 1 | Write enable flag |
| sr_i | input | 8 | Status byte to shift out |
| wel_set_o | output | 1 | Pulse: set write enable |
| wel_clr_o | output | 1 | Pulse: clear write enable |
| sr_we_o | output | 1 | Pulse: load status register |
| sr_wdata_o | output | 8 | Status data, masked |
| wr_start_o | output | 1 | Pulse: start timed write |
| mem_addr_o | output | 15 | Array address (read or commit) |
| mem_rdata_i | input | 8 | Array read data, combinational |
| mem_we_o | output | 1 | Array write strobe |
| mem_wdata_o | output | 8 | Array write data |
| prot_i | input | 1 | Address at `mem_addr_o` is protected |

## Verification
Two functions can land on the same serial step. A commit decision is made on the select rise, and that rise can follow directly on the clock edge that completes a data byte, or fall a few bits into the next byte. The bench provokes both and checks that exactly one `wr_start_o` pulse appears, or none. Its reference model also holds a queue of expected array writes, built from the requirements. On every clock, any `mem_we_o` must match an entry in that queue, so buffer wrap, overwrite and protected-address skipping are all judged at the array port.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_PHASE_BITS = 16;

  localparam logic [BYTE_W-1:0] OPC_SETWE = 8'h06;
  localparam logic [BYTE_W-1:0] OPC_CLRWE = 8'h04;
  localparam logic [BYTE_W-1:0] OPC_STRD  = 8'h05;
  localparam logic [BYTE_W-1:0] OPC_STWR  = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_ARD   = 8'h03;
  localparam logic [BYTE_W-1:0] OPC_AWR   = 8'h02;

  localparam logic [BYTE_W-1:0] STAT_KEEP = 8'h9C;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADR, PH_ARD, PH_SRD, PH_AWR, PH_SWR, PH_TAIL, PH_SKIP
  } phase_t;
endpackage

// File: rtl/eeprom_insync.sv
module eeprom_insync #(
  parameter int W = 4,
  parameter int EW = 3,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  lvl,
  output logic [EW-1:0] dly
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RSTV[g];
        s2_q <= RSTV[g];
      end else begin
        s1_q <= din[g];
        s2_q <= s1_q;
      end
    end
    assign lvl[g] = s2_q;
    if (g < EW) begin : g_edge
      logic s3_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s3_q <= RSTV[g];
        else        s3_q <= s2_q;
      end
      assign dly[g] = s3_q;
    end
  end
endmodule

// File: rtl/eeprom_pagebuf.sv
module eeprom_pagebuf #(
  parameter int AW = 15,
  parameter int PW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [PW-1:0] ld_off,
  input  logic [DW-1:0] ld_data,
  input  logic          go,
  input  logic [AW-PW-1:0] page,
  input  logic          prot,
  output logic          busy,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata
);
  localparam int DEPTH = 1 << PW;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PW-1:0]    ptr_q;
  logic             run_q;
  logic [AW-PW-1:0] pg_q;

  always_ff @(posedge clk) begin
    if (ld) mem_q[ld_off] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
      run_q <= 1'b0;
      pg_q  <= '0;
    end else begin
      if (clr)     vld_q <= '0;
      else if (ld) vld_q[ld_off] <= 1'b1;
      if (go) begin
        run_q <= 1'b1;
        ptr_q <= '0;
        pg_q  <= page;
      end else if (run_q) begin
        ptr_q <= ptr_q + 1'b1;
        if (&ptr_q) run_q <= 1'b0;
      end
    end
  end

  assign busy  = run_q;
  assign waddr = {pg_q, ptr_q};
  assign wdata = mem_q[ptr_q];
  assign we    = run_q & vld_q[ptr_q] & ~prot;
endmodule

// File: rtl/eeprom_cmd_engine.sv
module eeprom_cmd_engine
  import eeprom_pkg::*;
#(
  parameter int AW = 15,
  parameter int PW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  input  logic              busy_i,
  input  logic              wel_i,
  input  logic [BYTE_W-1:0] sr_i,
  output logic              wel_set_o,
  output logic              wel_clr_o,
  output logic              sr_we_o,
  output logic [BYTE_W-1:0] sr_wdata_o,
  output logic              wr_start_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic              prot_i
);
  localparam int SHW = ADDR_PHASE_BITS - 2;
  localparam int CW  = $clog2(ADDR_PHASE_BITS);

  logic [3:0] lvl;
  logic [2:0] dly;
  eeprom_insync #(.W(4), .EW(3), .RSTV(4'b0100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({si, hold_n, cs_n, sck}), .lvl(lvl), .dly(dly)
  );
  logic sck_s, sck_r, sck_f, cs_s, cs_r, cs_f, hold_s, hold_d, si_s;
  assign sck_s  = lvl[0];
  assign sck_r  = lvl[0] & ~dly[0];
  assign sck_f  = ~lvl[0] & dly[0];
  assign cs_s   = lvl[1];
  assign cs_r   = lvl[1] & ~dly[1];
  assign cs_f   = ~lvl[1] & dly[1];
  assign hold_s = lvl[2];
  assign hold_d = dly[2];
  assign si_s   = lvl[3];

  phase_t            phase_q, phase_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [SHW-1:0]    sh_q, sh_n;
  logic [AW-1:0]     addr_q, addr_n;
  logic [BYTE_W-1:0] op_q, op_n, srb_q, srb_n;
  logic [BYTE_W-2:0] osh_q, osh_n;
  logic active_q, active_n, paused_q, paused_n, got_q, got_n;
  logic so_q, so_n, oe_q, oe_n;
  logic set_n, clrw_n, srwe_n, start_n, go_n, ld_n, bclr_n;
  logic wel_set_q, wel_clr_q, sr_we_q, start_q;

  logic pb_busy, pb_we;
  logic [AW-1:0] pb_waddr;
  logic [BYTE_W-1:0] pb_wdata;

  logic [SHW:0]      sin;
  logic [CW-1:0]     cnt_inc;
  logic              ev_r, ev_f, byte_end, busy_any;
  logic [BYTE_W-1:0] src;
  assign sin      = {sh_q, si_s};
  assign cnt_inc  = cnt_q + 1'b1;
  assign ev_r     = active_q & ~paused_q & sck_r;
  assign ev_f     = active_q & ~paused_q & sck_f;
  assign byte_end = (cnt_q[2:0] == 3'd7);
  assign busy_any = busy_i | pb_busy;
  assign src      = (phase_q == PH_ARD) ? mem_rdata_i : sr_i;

  always_comb begin
    phase_n = phase_q;  cnt_n = cnt_q;  sh_n = sh_q;  addr_n = addr_q;
    op_n = op_q;  srb_n = srb_q;  osh_n = osh_q;  active_n = active_q;
    got_n = got_q;  so_n = so_q;  oe_n = oe_q;
    set_n = 1'b0;  clrw_n = 1'b0;  srwe_n = 1'b0;  start_n = 1'b0;
    go_n = 1'b0;  ld_n = 1'b0;  bclr_n = 1'b0;
    paused_n = !active_q ? 1'b0 : ((!sck_s && hold_s == hold_d) ? !hold_s : paused_q);
    if (cs_f) begin
      active_n = 1'b1;  phase_n = PH_CMD;  cnt_n = '0;  oe_n = 1'b0;  got_n = 1'b0;
    end else if (cs_r) begin
      active_n = 1'b0;  oe_n = 1'b0;
      if (active_q && phase_q == PH_TAIL) begin
        set_n  = (op_q == OPC_SETWE);
        clrw_n = (op_q == OPC_CLRWE);
        srwe_n = (op_q == OPC_STWR) & wel_i;
        start_n = srwe_n;
      end else if (active_q && phase_q == PH_AWR && cnt_q[2:0] == 3'd0 && got_q && wel_i) begin
        start_n = 1'b1;  go_n = 1'b1;
      end
    end else if (ev_r) begin
      sh_n  = sin[SHW-1:0];
      cnt_n = {1'b0, cnt_inc[2:0]};
      unique case (phase_q)
        PH_CMD: if (byte_end) begin
          cnt_n = '0;  op_n = sin[7:0];
          if (busy_any && sin[7:0] != OPC_STRD) phase_n = PH_SKIP;
          else if (sin[7:0] == OPC_SETWE || sin[7:0] == OPC_CLRWE) phase_n = PH_TAIL;
          else if (sin[7:0] == OPC_STRD) phase_n = PH_SRD;
          else if (sin[7:0] == OPC_STWR) phase_n = PH_SWR;
          else if (sin[7:0] == OPC_ARD)  phase_n = PH_ADR;
          else if (sin[7:0] == OPC_AWR) begin phase_n = PH_ADR;  bclr_n = 1'b1; end
          else phase_n = PH_SKIP;
        end
        PH_ADR: begin
          cnt_n = cnt_inc;
          if (&cnt_q) begin
            addr_n  = sin[AW-1:0];  cnt_n = '0;  got_n = 1'b0;
            phase_n = (op_q == OPC_ARD) ? PH_ARD : PH_AWR;
          end
        end
        PH_ARD: if (byte_end) addr_n = addr_q + 1'b1;
        PH_AWR: if (byte_end) begin
          ld_n   = 1'b1;  got_n = 1'b1;
          addr_n = {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
        end
        PH_SWR: if (byte_end) begin srb_n = sin[7:0];  phase_n = PH_TAIL;  cnt_n = '0; end
        PH_TAIL: phase_n = PH_SKIP;
        default: ;
      endcase
    end else if (ev_f && (phase_q == PH_ARD || phase_q == PH_SRD)) begin
      if (cnt_q[2:0] == 3'd0) begin
        so_n = src[BYTE_W-1];  osh_n = src[BYTE_W-2:0];  oe_n = 1'b1;
      end else begin
        so_n = osh_q[BYTE_W-2];  osh_n = {osh_q[BYTE_W-3:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SKIP;  cnt_q <= '0;  sh_q <= '0;  addr_q <= '0;
      op_q <= '0;  srb_q <= '0;  osh_q <= '0;  active_q <= 1'b0;
      paused_q <= 1'b0;  got_q <= 1'b0;  so_q <= 1'b0;  oe_q <= 1'b0;
      wel_set_q <= 1'b0;  wel_clr_q <= 1'b0;  sr_we_q <= 1'b0;  start_q <= 1'b0;
    end else begin
      phase_q <= phase_n;  cnt_q <= cnt_n;  sh_q <= sh_n;  addr_q <= addr_n;
      op_q <= op_n;  srb_q <= srb_n;  osh_q <= osh_n;  active_q <= active_n;
      paused_q <= paused_n;  got_q <= got_n;  so_q <= so_n;  oe_q <= oe_n;
      wel_set_q <= set_n;  wel_clr_q <= clrw_n;  sr_we_q <= srwe_n;  start_q <= start_n;
    end
  end

  eeprom_pagebuf #(.AW(AW), .PW(PW), .DW(BYTE_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clr(bclr_n), .ld(ld_n), .ld_off(addr_q[PW-1:0]),
    .ld_data(sin[7:0]), .go(go_n), .page(addr_q[AW-1:PW]), .prot(prot_i),
    .busy(pb_busy), .we(pb_we), .waddr(pb_waddr), .wdata(pb_wdata)
  );

  assign so          = so_q;
  assign so_oe       = oe_q & active_q & ~paused_q & ~cs_s;
  assign wel_set_o   = wel_set_q;
  assign wel_clr_o   = wel_clr_q;
  assign sr_we_o     = sr_we_q;
  assign sr_wdata_o  = srb_q & STAT_KEEP;
  assign wr_start_o  = start_q;
  assign mem_addr_o  = pb_busy ? pb_waddr : addr_q;
  assign mem_we_o    = pb_we;
  assign mem_wdata_o = pb_wdata;
endmodule

// File: rtl/eeprom_cmd_chk.sv
module eeprom_cmd_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic hold_n,
  input logic so_oe,
  input logic mem_we_o,
  input logic prot_i,
  input logic wel_set_o,
  input logic wel_clr_o,
  input logic wr_start_o,
  input logic sr_we_o
);
  AST_FLOAT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !so_oe); // R9
  AST_FLOAT_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !sck && $past(!hold_n && !sck) && $past(!hold_n && !sck, 2)
     && $past(!hold_n && !sck, 3) && $past(!hold_n && !sck, 4)) |-> !so_oe); // R8
  AST_NO_PROT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !prot_i); // R11
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wel_set_o, wel_clr_o, wr_start_o})); // R6
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |=> !wr_start_o); // R5
  AST_STATUS_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we_o |-> wr_start_o); // R7
endmodule

bind eeprom_cmd_engine eeprom_cmd_chk u_chk (.*);

// File: tb/eeprom_cmd_engine_bench.sv
module eeprom_cmd_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic busy_i = 1'b0, wel_i = 1'b0;
  logic [7:0] sr_i = 8'h00;
  logic so, so_oe, wel_set_o, wel_clr_o, sr_we_o, wr_start_o, mem_we_o, prot_i;
  logic [7:0] sr_wdata_o, mem_rdata_i, mem_wdata_o;
  logic [14:0] mem_addr_o;

  logic [7:0] arr [32768];
  logic [7:0] model [32768];
  int exp_q[$];
  bit prot_en = 0;
  int prot_lim = 0;
  int checks = 0, errors = 0;
  int n_set = 0, n_clr = 0, n_start = 0, n_srwe = 0, hi_cnt = 0;
  bit idle_hi = 0, done = 0;

  always #2.5 clk = ~clk;

  eeprom_cmd_engine u_eeprom_cmd_engine (.*);

  assign mem_rdata_i = arr[mem_addr_o];
  assign prot_i = prot_en && (int'(mem_addr_o) < prot_lim);
  always @(posedge clk) if (mem_we_o) arr[mem_addr_o] <= mem_wdata_o;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    hi_cnt = cs_n ? hi_cnt + 1 : 0;
    if (rst_n) begin
      if (wel_set_o) n_set++;
      if (wel_clr_o) n_clr++;
      if (wr_start_o) n_start++;
      if (sr_we_o) n_srwe++;
      if (hi_cnt >= 6) chk(!so_oe, "R9", "so_oe while deselected", so_oe, 0);
      if (mem_we_o) begin
        int idx[$];
        idx = exp_q.find_first_index(x) with (x == int'(mem_addr_o));
        chk(idx.size() == 1, "R11", "unexpected array write addr", mem_addr_o, 0);
        if (idx.size() == 1) begin
          chk(mem_wdata_o == model[mem_addr_o], "R4", "write data", mem_wdata_o, model[mem_addr_o]);
          exp_q.delete(idx[0]);
        end
      end
    end
  end

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic r, output logic oe);
    if (idle_hi) sck = 1'b0;
    si = b;
    wclk(6);
    r = so;  oe = so_oe;
    sck = 1'b1;
    wclk(6);
    if (!idle_hi) sck = 1'b0;
  endtask

  task automatic bytex(input logic [7:0] tx, output logic [7:0] rx, output bit oe_all);
    oe_all = 1;
    for (int i = 7; i >= 0; i--) begin
      logic r, oe;
      bitx(tx[i], r, oe);
      rx[i] = r;
      oe_all &= oe;
    end
  endtask

  task automatic sel(); cs_n = 1'b0; wclk(6); endtask
  task automatic desel(); wclk(6); cs_n = 1'b1; wclk(10); endtask

  task automatic read_chk(int a, int n);
    logic [7:0] rx; bit oe;
    sel();
    bytex(8'h03, rx, oe);
    bytex(8'(a >> 8), rx, oe);
    bytex(8'(a), rx, oe);
    for (int i = 0; i < n; i++) begin
      int ea = (a + i) & 32'h7FFF;
      bytex(8'h00, rx, oe);
      chk(rx == model[ea] && oe, "R3", "read stream byte", rx, model[ea]);
    end
    desel();
  endtask

  task automatic page_write(int a, int n, int seed, int cut);
    logic [7:0] rx; bit oe; logic r, o;
    logic [7:0] tmp [64];
    bit vld [64];
    bit commit = wel_i && cut == 0 && n >= 1;
    int s0 = n_start;
    int off = a & 63;
    for (int i = 0; i < 64; i++) vld[i] = 0;
    sel();
    bytex(8'h02, rx, oe);
    bytex(8'(a >> 8), rx, oe);
    bytex(8'(a), rx, oe);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'(seed + i * 3);
      bytex(d, rx, oe);
      tmp[off] = d;  vld[off] = 1;  off = (off + 1) & 63;
    end
    for (int i = 0; i < cut; i++) bitx(1'b1, r, o);
    if (commit)
      for (int i = 0; i < 64; i++)
        if (vld[i]) begin
          int wa = (a & 32'h7FC0) | i;
          if (!(prot_en && wa < prot_lim)) begin
            model[wa] = tmp[i];
            exp_q.push_back(wa);
          end
        end
    desel();
    chk(n_start - s0 == (commit ? 1 : 0), "R5", "commit pulses", n_start - s0, commit ? 1 : 0);
    wclk(80);
    chk(exp_q.size() == 0, "R11", "pending writes left", exp_q.size(), 0);
  endtask

  initial begin
    logic [7:0] rx; bit oe; logic r, o;
    int s, c;
    for (int i = 0; i < 32768; i++) begin
      arr[i] = 8'((i * 37 + 11) ^ (i >> 8));
      model[i] = arr[i];
    end
    cs_n = 1'b0;
    sr_i = 8'h5A;
    wclk(5);
    rst_n = 1'b1;
    wclk(4);
    // R9: select held low through reset gives no response
    bytex(8'h05, rx, oe);
    bytex(8'h00, rx, oe);
    chk(!oe, "R9", "response without select fall", oe, 0);
    cs_n = 1'b1;
    wclk(10);
    chk(!so_oe && !mem_we_o && !wr_start_o, "R9", "reset state", {so_oe, mem_we_o, wr_start_o}, 0);

    // R1 R3: array read, top address bit ignored, wrap at end
    read_chk(32'h9234, 3);
    read_chk(32'h7FFE, 4);

    // R12 R2: status read repeats, mode 0 then mode 3
    sel();
    bytex(8'h05, rx, oe);
    bytex(8'h00, rx, oe);
    chk(rx == 8'h5A && oe, "R12", "status byte", rx, 8'h5A);
    bytex(8'h00, rx, oe);
    chk(rx == 8'h5A && oe, "R12", "status repeat", rx, 8'h5A);
    desel();
    idle_hi = 1;  sck = 1'b1;  sr_i = 8'hC3;  wclk(10);
    sel();
    bytex(8'h05, rx, oe);
    bytex(8'h00, rx, oe);
    chk(rx == 8'hC3 && oe, "R2", "mode 3 status", rx, 8'hC3);
    desel();
    idle_hi = 0;  sck = 1'b0;  wclk(10);

    // R6: write enable set/clear, extra bit cancels
    s = n_set;
    sel(); bytex(8'h06, rx, oe); desel();
    chk(n_set - s == 1, "R6", "set pulse", n_set - s, 1);
    s = n_set;
    sel(); bytex(8'h06, rx, oe); bitx(1'b0, r, o); desel();
    chk(n_set - s == 0, "R6", "set cancelled by extra bit", n_set - s, 0);
    c = n_clr;
    sel(); bytex(8'h04, rx, oe); desel();
    chk(n_clr - c == 1, "R6", "clear pulse", n_clr - c, 1);

    // R5: no write enable -> discarded
    wel_i = 1'b0;
    page_write(32'h0100, 2, 8'h40, 0);
    wel_i = 1'b1;
    // R4: wrap inside page, top bit ignored
    page_write(32'h813E, 4, 8'h10, 0);
    read_chk(32'h013E, 4);
    // R4: 66 bytes, first two overwritten
    page_write(32'h0200, 66, 8'h01, 0);
    chk(arr[32'h0200] == 8'(8'h01 + 64 * 3), "R4", "overwrite of offset 0", arr[32'h0200], 8'(8'h01 + 64 * 3));
    // R5: select rise mid-byte discards
    page_write(32'h0300, 1, 8'h77, 3);
    // R11: protected addresses skipped
    prot_en = 1;  prot_lim = 32'h0302;
    page_write(32'h0300, 3, 8'h90, 0);
    chk(arr[32'h0300] == model[32'h0300] && arr[32'h0302] == 8'h96, "R11", "protected skip", arr[32'h0302], 8'h96);
    prot_en = 0;

    // R7: status write masking and cancel cases
    s = n_srwe;
    sel(); bytex(8'h01, rx, oe); bytex(8'hFF, rx, oe); desel();
    chk(n_srwe - s == 1 && sr_wdata_o == 8'h9C, "R7", "status write data", sr_wdata_o, 8'h9C);
    s = n_srwe;
    sel(); bytex(8'h01, rx, oe); bytex(8'h80, rx, oe); bitx(1'b0, r, o); desel();
    chk(n_srwe - s == 0, "R7", "status write cut", n_srwe - s, 0);
    wel_i = 1'b0;  s = n_srwe;
    sel(); bytex(8'h01, rx, oe); bytex(8'h80, rx, oe); desel();
    chk(n_srwe - s == 0, "R7", "status write without enable", n_srwe - s, 0);

    // R10: busy blocks all but status read; unknown opcode ignored
    busy_i = 1'b1;  sr_i = 8'h01;
    sel(); bytex(8'h03, rx, oe); bytex(8'h00, rx, oe); bytex(8'h00, rx, oe); bytex(8'h00, rx, oe); desel();
    chk(!oe, "R10", "read while busy", oe, 0);
    s = n_set;
    sel(); bytex(8'h06, rx, oe); desel();
    chk(n_set - s == 0, "R10", "set while busy", n_set - s, 0);
    sel(); bytex(8'h05, rx, oe); bytex(8'h00, rx, oe); desel();
    chk(rx == 8'h01 && oe, "R10", "status while busy", rx, 8'h01);
    busy_i = 1'b0;
    s = n_set + n_clr + n_start;
    sel(); bytex(8'hAB, rx, oe); bytex(8'h06, rx, oe); desel();
    chk(!oe && n_set + n_clr + n_start == s, "R10", "unknown opcode", oe, 0);

    // R8: pause in the middle of a read byte
    sel();
    bytex(8'h03, rx, oe); bytex(8'h00, rx, oe); bytex(8'h40, rx, oe);
    bytex(8'h00, rx, oe);
    chk(rx == model[32'h40], "R8", "byte before pause", rx, model[32'h40]);
    for (int i = 7; i >= 4; i--) begin bitx(1'b0, r, o); rx[i] = r; end
    hold_n = 1'b0;  wclk(8);
    chk(!so_oe, "R8", "output floats in pause", so_oe, 0);
    repeat (2) begin sck = 1'b1; si = 1'b1; wclk(6); sck = 1'b0; wclk(6); end
    hold_n = 1'b1;  wclk(8);
    for (int i = 3; i >= 0; i--) begin bitx(1'b0, r, o); rx[i] = r; end
    chk(rx == model[32'h41], "R8", "byte across pause", rx, model[32'h41]);
    bytex(8'h00, rx, oe);
    chk(rx == model[32'h42] && oe, "R8", "byte after pause", rx, model[32'h42]);
    desel();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule